// File: doc/BRIEF.md
# Look-Up-Table Cell with Per-Bit Usage Classification

This block is a four-input look-up-table cell whose sixteen configuration bits are each tracked by operating mode. Every accepted access marks the addressed bit as used in normal operation or in emergency operation. The mode comes from a one-bit flag that an outside threshold comparator raises when the monitored value has reached or exceeded its threshold. The marks stay set until software-independent logic clears them with a synchronous clear.

From the two mark vectors the block derives four disjoint usage classes: never used, normal only, emergency only (the emergency-used set with the normal-used bits removed), and used in both modes. It reports a count for each class and a count of all used bits. A fault-injection input inverts the cell output so that a downstream observer can tell whether the addressed bit influences the result.

Top module: `lut_usage_monitor`

## Requirements
- R1: `cellOut` combinationally equals configuration bit number `selIn`, where `selIn[3]` is input D (most significant), then C, B and `selIn[0]` is A; for example `selIn` = 4'b1010 reads bit 10.
- R2: While `faultInv` is 1, `cellOut` is the inverse of the addressed configuration bit.
- R3: `cfgLoad` = 1 writes `cfgData` into the configuration register at the clock edge. In the load cycle the output still shows the old contents. A load never changes the usage marks.
- R4: At a clock edge with `accValid` = 1, bit `selIn` of `normUsed` is set when `emergFlag` = 0 and bit `selIn` of `emergUsed` is set when `emergFlag` = 1. With `accValid` = 0, no mark changes.
- R5: Usage marks are sticky. A set bit stays set until `usageClear` or reset.
- R6: `usageClear` = 1 clears both mark vectors at the edge. If `accValid` = 1 in the same cycle, the marks afterwards hold exactly that one access.
- R7: `bothCnt`, `normOnlyCnt`, `emergOnlyCnt` and `unusedCnt` count the bits that are set in both vectors, only in `normUsed`, only in `emergUsed`, and in neither. Each count is 5 bits wide, so 16 can be represented, and the four counts always sum to 16.
- R8: `usedCnt` counts the bits set in at least one vector and always equals 16 minus `unusedCnt`.
- R9: An asynchronous low `rst_n` clears the configuration register and both mark vectors, so `unusedCnt` is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| selIn | input | 4 | Cell inputs {D,C,B,A} |
| emergFlag | input | 1 | 1 when the monitored value is at or above the threshold |
| accValid | input | 1 | Access strobe that allows the marks to update |
| faultInv | input | 1 | Inverts the cell output |
| cfgLoad | input | 1 | Configuration write strobe |
| cfgData | input | 16 | Configuration write data |
| usageClear | input | 1 | Synchronous clear of the usage marks |
| cellOut | output | 1 | Cell output |
| normUsed | output | 16 | Bits addressed in normal mode |
| emergUsed | output | 16 | Bits addressed in emergency mode |
| bothCnt | output | 5 | Bits used in both modes |
| normOnlyCnt | output | 5 | Bits used only in normal mode |
| emergOnlyCnt | output | 5 | Bits used only in emergency mode |
| unusedCnt | output | 5 | Bits never used |
| usedCnt | output | 5 | Bits used in any mode |

## Verification
A clear and an access can fall in the same cycle, and so can a configuration load and an access. The bench drives `usageClear` and `accValid` together in both modes and expects the marks to hold only that one access. It also loads a new pattern while reading and marking, and expects the old bit on the output and no change to the existing marks. A behavioural reference model decides these cases, and the outputs are compared against it before every clock edge.

// File: rtl/lum_pkg.sv
package lum_pkg;
  typedef struct packed {
    logic cfgWe;
    logic clearAll;
    logic markNorm;
    logic markEmerg;
  } lumStrobe_t;
endpackage

// File: rtl/lum_ctrl.sv
module lum_ctrl
  import lum_pkg::*;
(
  input  logic       accValid,
  input  logic       emergFlag,
  input  logic       cfgLoad,
  input  logic       usageClear,
  output lumStrobe_t strb
);
  always_comb begin
    strb.cfgWe     = cfgLoad;
    strb.clearAll  = usageClear;
    strb.markNorm  = accValid & ~emergFlag;
    strb.markEmerg = accValid &  emergFlag;
  end
endmodule

// File: rtl/lum_popcnt.sv
module lum_popcnt #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [CNT_W-1:0] cntOut
);
  always_comb begin
    cntOut = '0;
    for (int i = 0; i < WIDTH; i++) cntOut = cntOut + CNT_W'(vecIn[i]);
  end
endmodule

// File: rtl/lum_datapath.sv
module lum_datapath
  import lum_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lumStrobe_t        strb,
  input  logic [ADDR_W-1:0] selIn,
  input  logic              faultInv,
  input  logic [DEPTH-1:0]  cfgData,
  output logic              cellOut,
  output logic [DEPTH-1:0]  normQ,
  output logic [DEPTH-1:0]  emergQ
);
  logic [DEPTH-1:0] cfgQ;
  logic [DEPTH-1:0] addrHot;
  logic [DEPTH-1:0] normNext, emergNext;

  assign addrHot = DEPTH'(1) << selIn;
  assign cellOut = cfgQ[selIn] ^ faultInv;

  always_comb begin
    normNext  = strb.clearAll ? '0 : normQ;
    emergNext = strb.clearAll ? '0 : emergQ;
    if (strb.markNorm)  normNext  = normNext  | addrHot;
    if (strb.markEmerg) emergNext = emergNext | addrHot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ   <= '0;
      normQ  <= '0;
      emergQ <= '0;
    end else begin
      if (strb.cfgWe) cfgQ <= cfgData;
      normQ  <= normNext;
      emergQ <= emergNext;
    end
  end
endmodule

// File: rtl/lut_usage_monitor.sv
module lut_usage_monitor
  import lum_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] selIn,
  input  logic              emergFlag,
  input  logic              accValid,
  input  logic              faultInv,
  input  logic              cfgLoad,
  input  logic [DEPTH-1:0]  cfgData,
  input  logic              usageClear,
  output logic              cellOut,
  output logic [DEPTH-1:0]  normUsed,
  output logic [DEPTH-1:0]  emergUsed,
  output logic [CNT_W-1:0]  bothCnt,
  output logic [CNT_W-1:0]  normOnlyCnt,
  output logic [CNT_W-1:0]  emergOnlyCnt,
  output logic [CNT_W-1:0]  unusedCnt,
  output logic [CNT_W-1:0]  usedCnt
);
  lumStrobe_t strb;
  logic [DEPTH-1:0] classVec [5];

  lum_ctrl ctrl_i (
    .accValid(accValid), .emergFlag(emergFlag), .cfgLoad(cfgLoad),
    .usageClear(usageClear), .strb(strb)
  );

  lum_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .selIn(selIn),
    .faultInv(faultInv), .cfgData(cfgData), .cellOut(cellOut),
    .normQ(normUsed), .emergQ(emergUsed)
  );

  assign classVec[0] = normUsed & emergUsed;
  assign classVec[1] = normUsed & ~emergUsed;
  assign classVec[2] = emergUsed & ~normUsed;
  assign classVec[3] = ~(normUsed | emergUsed);
  assign classVec[4] = normUsed | emergUsed;

  logic [CNT_W-1:0] classCnt [5];
  for (genvar g = 0; g < 5; g++) begin : g_cnt
    lum_popcnt #(.WIDTH(DEPTH), .CNT_W(CNT_W)) pc_i (
      .vecIn(classVec[g]), .cntOut(classCnt[g])
    );
  end

  assign bothCnt      = classCnt[0];
  assign normOnlyCnt  = classCnt[1];
  assign emergOnlyCnt = classCnt[2];
  assign unusedCnt    = classCnt[3];
  assign usedCnt      = classCnt[4];
endmodule

// File: rtl/lum_checker.sv
module lum_checker #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] selIn,
  input logic              emergFlag,
  input logic              accValid,
  input logic              faultInv,
  input logic              cfgLoad,
  input logic [DEPTH-1:0]  cfgData,
  input logic              usageClear,
  input logic              cellOut,
  input logic [DEPTH-1:0]  normUsed,
  input logic [DEPTH-1:0]  emergUsed,
  input logic [CNT_W-1:0]  bothCnt,
  input logic [CNT_W-1:0]  normOnlyCnt,
  input logic [CNT_W-1:0]  emergOnlyCnt,
  input logic [CNT_W-1:0]  unusedCnt,
  input logic [CNT_W-1:0]  usedCnt
);
  logic loadBit;
  assign loadBit = cfgData[selIn];

  AST_LOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLoad ##1 $stable(selIn)) |-> (cellOut == ($past(loadBit) ^ faultInv))); // R3
  AST_MARK_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !emergFlag) |=> normUsed[$past(selIn)]); // R4
  AST_MARK_EMERG: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && emergFlag) |=> emergUsed[$past(selIn)]); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !usageClear |=> (((normUsed & $past(normUsed)) == $past(normUsed)) &&
                     ((emergUsed & $past(emergUsed)) == $past(emergUsed)))); // R5
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (usageClear && !accValid) |=> (normUsed == '0 && emergUsed == '0)); // R6
  AST_CLASS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bothCnt) + 32'(normOnlyCnt) + 32'(emergOnlyCnt) + 32'(unusedCnt)) == DEPTH); // R7
  AST_USED_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(usedCnt) + 32'(unusedCnt)) == DEPTH); // R8
endmodule

bind lut_usage_monitor lum_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/lut_usage_monitor_tb.sv
module lut_usage_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] selIn = '0;
  logic emergFlag = 1'b0, accValid = 1'b0, faultInv = 1'b0, cfgLoad = 1'b0, usageClear = 1'b0;
  logic [15:0] cfgData = '0;
  logic cellOut;
  logic [15:0] normUsed, emergUsed;
  logic [4:0] bothCnt, normOnlyCnt, emergOnlyCnt, unusedCnt, usedCnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] mCfg = '0, mN = '0, mE = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_usage_monitor dut_i (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    string rtag;
    rtag = cfgLoad ? "R3" : (faultInv ? "R2" : "R1");
    chk(rtag, "cellOut", int'(cellOut), int'(mCfg[selIn] ^ faultInv));
    chk("R4", "normUsed", int'(normUsed), int'(mN));
    chk("R4", "emergUsed", int'(emergUsed), int'(mE));
    chk("R7", "bothCnt", int'(bothCnt), $countones(mN & mE));
    chk("R7", "normOnlyCnt", int'(normOnlyCnt), $countones(mN & ~mE));
    chk("R7", "emergOnlyCnt", int'(emergOnlyCnt), $countones(mE & ~mN));
    chk("R7", "unusedCnt", int'(unusedCnt), $countones(~(mN | mE)));
    chk("R8", "usedCnt", int'(usedCnt), $countones(mN | mE));
  endtask

  task automatic doCycle(input logic [3:0] s, input logic e, input logic v, input logic f,
                         input logic l, input logic [15:0] d, input logic c);
    @(negedge clk);
    selIn = s; emergFlag = e; accValid = v; faultInv = f;
    cfgLoad = l; cfgData = d; usageClear = c;
    #(CLK_PERIOD/2 - 1);
    compareAll();
    if (c) begin mN = '0; mE = '0; end
    if (v) begin
      if (e) mE[s] = 1'b1; else mN[s] = 1'b1;
    end
    if (l) mCfg = d;
  endtask

  task automatic settle();
    @(negedge clk);
    selIn = '0; accValid = 0; cfgLoad = 0; usageClear = 0; faultInv = 0; emergFlag = 0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "reset unusedCnt", int'(unusedCnt), 16);
    chk("R9", "reset normUsed", int'(normUsed), 0);
    chk("R9", "reset emergUsed", int'(emergUsed), 0);
    chk("R9", "reset cellOut", int'(cellOut), 0);
    @(negedge clk); rst_n = 1'b1;

    doCycle(4'd0, 0, 0, 0, 1, 16'hA5C3, 0);
    for (int i = 0; i < 16; i++) doCycle(4'(i), 0, 0, 0, 0, '0, 0);
    for (int i = 0; i < 16; i++) doCycle(4'(i), 1, 0, 1, 0, '0, 0);
    settle(); selIn = 4'b1010; #1;
    chk("R1", "bit10 via D,C,B,A=1010", int'(cellOut), int'(mCfg[10]));
    chk("R4", "no mark without accValid", int'(normUsed | emergUsed), 0);

    for (int i = 0; i < 6; i++) doCycle(4'(i), 0, 1, 0, 0, '0, 0);
    for (int i = 4; i < 10; i++) doCycle(4'(i), 1, 1, 0, 0, '0, 0);
    settle();
    chk("R7", "both after mix", int'(bothCnt), 2);
    chk("R7", "emergOnly after mix", int'(emergOnlyCnt), 4);
    chk("R7", "normOnly after mix", int'(normOnlyCnt), 4);
    chk("R8", "used after mix", int'(usedCnt), 10);

    for (int i = 0; i < 8; i++) doCycle(4'(i + 3), 0, 0, 1, 0, '0, 0);
    settle();
    chk("R5", "sticky normUsed", int'(normUsed), 16'h003F);

    doCycle(4'd3, 0, 1, 0, 1, 16'h5A3C, 0);
    doCycle(4'd3, 1, 1, 0, 0, '0, 0);
    settle();
    chk("R3", "load kept marks", int'(normUsed), 16'h003F);

    for (int i = 0; i < 16; i++) doCycle(4'(i), 0, 1, 0, 0, '0, 0);
    for (int i = 0; i < 16; i++) doCycle(4'(15 - i), 1, 1, 0, 0, '0, 0);
    settle();
    chk("R7", "bothCnt reaches 16", int'(bothCnt), 16);
    chk("R7", "unused at full", int'(unusedCnt), 0);

    doCycle(4'd7, 1, 1, 0, 0, '0, 1);
    settle();
    chk("R6", "clear+emerg access normUsed", int'(normUsed), 0);
    chk("R6", "clear+emerg access emergUsed", int'(emergUsed), 16'h0080);
    doCycle(4'd2, 0, 1, 0, 0, '0, 1);
    settle();
    chk("R6", "clear+norm access normUsed", int'(normUsed), 16'h0004);
    chk("R6", "clear+norm access emergUsed", int'(emergUsed), 0);
    doCycle(4'd9, 0, 0, 0, 0, '0, 1);
    doCycle(4'd9, 0, 0, 0, 0, '0, 0);
    settle();
    chk("R6", "plain clear unused", int'(unusedCnt), 16);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule